// File: doc/BRIEF.md
# Indirect CSR Access Fault Checker

This block decides whether an instruction that touches one of the indirect-access CSR windows must trap. There are three windows: machine-level at 0x350, supervisor-level at 0x150 and virtual-supervisor-level at 0x250. Each window holds a select register at offset 0 and alias registers at offsets 1, 2, 3, 5, 6 and 7. Offset 4 is not part of any window. The checker takes the CSR address, the current privilege and a virtualization flag. It also takes bit 60 of the machine and hypervisor state-enable registers, and a flag from the window unit that reports an unimplemented select value. From these it produces at most one fault, either illegal-instruction or virtual-instruction.

The verdict is computed in one combinational stage and registered. The fault outputs are therefore valid one clock after the request inputs are presented. Parameters remove the hypervisor or state-enable features. When state-enable is absent, both enable bits act as 1. When the hypervisor is absent, the virtualization flag is ignored and every access to the virtual-supervisor window is illegal.

Top module: `csri_access_checker`

## Requirements
- R1: While reset is asserted, both fault outputs are 0, whatever the request inputs are.
- R2: Addresses outside the three windows produce no fault. This includes the unused offset 4 and offsets 8 and above.
- R3: In the machine window (0x350–0x357), any access from a mode other than M raises a fault. The fault is virtual-instruction if the hart is virtualized and illegal-instruction otherwise. Privilege encoding: U=2'b00, S=2'b01, M=2'b11.
- R4: If machine state-enable bit 60 is 0, an access from below M to the supervisor or virtual-supervisor window raises illegal-instruction. This takes priority over every virtual-instruction rule.
- R5: In M-mode, neither state-enable bit ever causes a fault.
- R6: If machine bit 60 is 1, an access from VS or VU to the virtual-supervisor window raises virtual-instruction.
- R7: If machine bit 60 is 1, an access from VU to the supervisor window raises virtual-instruction.
- R8: If hypervisor bit 60 is 0 and machine bit 60 is 1, an access from VS to the supervisor window raises virtual-instruction, even when the select is unimplemented.
- R9: An access from non-virtualized U-mode to the supervisor or virtual-supervisor window raises illegal-instruction.
- R10: An alias access (offsets 1–3 and 5–7) that no earlier rule faults raises illegal-instruction when the unimplemented-select flag is 1. This includes VS-mode alias access to the supervisor window. A select-register access (offset 0) ignores the flag.
- R11: The two fault outputs are never both 1. Each verdict appears in the cycle after the clock edge that samples its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | CSR address of the access |
| priv_lvl | input | 2 | Current privilege (U=00, S=01, M=11) |
| virt_on | input | 1 | Hart is running virtualized (VS/VU) |
| menable_ind | input | 1 | Machine state-enable bit 60 |
| henable_ind | input | 1 | Hypervisor state-enable bit 60 |
| sel_unimpl | input | 1 | The current select value is not implemented |
| fault_illegal | output | 1 | Illegal-instruction fault |
| fault_virtual | output | 1 | Virtual-instruction fault |

## Verification
Every verdict takes exactly one register stage. Faults for a request presented before a rising edge appear just after that edge. The bench drives each request on a falling edge and lets one rising edge pass. It then compares both outputs on the next falling edge, before any new request is driven, so a stale or early verdict shows up as a mismatch. The sweep covers every window offset and several neighbouring addresses. It crosses them with all five legal privilege/virtualization states and all eight combinations of the two enable bits and the unimplemented-select flag.

// File: rtl/csri_pkg.sv
package csri_pkg;

    localparam int unsigned ADDR_W = 12;

    typedef enum logic [1:0] {
        PRV_U = 2'b00,
        PRV_S = 2'b01,
        PRV_M = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_MACH = 2'd1,
        CLS_SUP  = 2'd2,
        CLS_VSUP = 2'd3
    } win_cls_e;

    typedef struct packed {
        logic illegal;
        logic virt;
    } csri_fault_t;

endpackage

// File: rtl/csri_addr_decode.sv
module csri_addr_decode
    import csri_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MACH_BASE = 12'h350,
    parameter logic [ADDR_W-1:0] SUP_BASE  = 12'h150,
    parameter logic [ADDR_W-1:0] VSUP_BASE = 12'h250
) (
    input  logic [ADDR_W-1:0] addr,
    output win_cls_e          cls,
    output logic              is_alias
);
    localparam int unsigned NWIN  = 3;
    localparam int unsigned OFF_W = 4;
    localparam logic [OFF_W-1:0] HOLE_OFF = 4'd4;
    localparam logic [OFF_W-1:0] LAST_OFF = 4'd7;

    logic [NWIN-1:0] hit;
    logic [OFF_W-1:0] off;

    assign off = addr[OFF_W-1:0];

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        localparam logic [ADDR_W-1:0] BASE =
            (w == 0) ? MACH_BASE : (w == 1) ? SUP_BASE : VSUP_BASE;
        assign hit[w] = (addr[ADDR_W-1:OFF_W] == BASE[ADDR_W-1:OFF_W])
                        && (off <= LAST_OFF) && (off != HOLE_OFF);
    end

    always_comb begin
        cls = CLS_NONE;
        if (hit[0])      cls = CLS_MACH;
        else if (hit[1]) cls = CLS_SUP;
        else if (hit[2]) cls = CLS_VSUP;
    end

    assign is_alias = (|hit) && (off != '0);

endmodule

// File: rtl/csri_fault_rules.sv
module csri_fault_rules
    import csri_pkg::*;
#(
    parameter bit HAS_HYP     = 1'b1,
    parameter bit HAS_STATEEN = 1'b1
) (
    input  win_cls_e    cls,
    input  logic        is_alias,
    input  logic [1:0]  priv,
    input  logic        virt,
    input  logic        men,
    input  logic        hen,
    input  logic        unimpl,
    output csri_fault_t fault
);
    logic is_m, is_u, v, m_ok, h_ok, sel_bad;

    always_comb begin
        is_m    = (priv == PRV_M);
        is_u    = (priv == PRV_U);
        v       = HAS_HYP && virt && !is_m;
        m_ok    = !HAS_STATEEN || men;
        h_ok    = !HAS_STATEEN || !HAS_HYP || hen;
        sel_bad = is_alias && unimpl;
        fault   = '0;
        case (cls)
            CLS_MACH: begin
                if (!is_m) begin
                    if (v) fault.virt    = 1'b1;
                    else   fault.illegal = 1'b1;
                end else if (sel_bad) begin
                    fault.illegal = 1'b1;
                end
            end
            CLS_SUP: begin
                if (!is_m && !m_ok)       fault.illegal = 1'b1;
                else if (v && is_u)       fault.virt    = 1'b1;
                else if (v && !h_ok)      fault.virt    = 1'b1;
                else if (is_u)            fault.illegal = 1'b1;
                else if (sel_bad)         fault.illegal = 1'b1;
            end
            CLS_VSUP: begin
                if (!HAS_HYP)             fault.illegal = 1'b1;
                else if (!is_m && !m_ok)  fault.illegal = 1'b1;
                else if (v)               fault.virt    = 1'b1;
                else if (is_u)            fault.illegal = 1'b1;
                else if (sel_bad)         fault.illegal = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/csri_access_checker.sv
module csri_access_checker
    import csri_pkg::*;
#(
    parameter bit HAS_HYP     = 1'b1,
    parameter bit HAS_STATEEN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [1:0]        priv_lvl,
    input  logic              virt_on,
    input  logic              menable_ind,
    input  logic              henable_ind,
    input  logic              sel_unimpl,
    output logic              fault_illegal,
    output logic              fault_virtual
);
    win_cls_e    cls;
    logic        is_alias;
    csri_fault_t verdict;
    csri_fault_t fault_d, fault_q;

    csri_addr_decode u_decode (
        .addr     (csr_addr),
        .cls      (cls),
        .is_alias (is_alias)
    );

    csri_fault_rules #(
        .HAS_HYP     (HAS_HYP),
        .HAS_STATEEN (HAS_STATEEN)
    ) u_rules (
        .cls      (cls),
        .is_alias (is_alias),
        .priv     (priv_lvl),
        .virt     (virt_on),
        .men      (menable_ind),
        .hen      (henable_ind),
        .unimpl   (sel_unimpl),
        .fault    (verdict)
    );

    always_comb begin
        fault_d = verdict;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_q <= '0;
        else        fault_q <= fault_d;
    end

    assign fault_illegal = fault_q.illegal;
    assign fault_virtual = fault_q.virt;

endmodule

// File: rtl/csri_access_checker_sva.sv
module csri_access_checker_sva #(
    parameter bit HAS_HYP     = 1'b1,
    parameter bit HAS_STATEEN = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] csr_addr,
    input logic [1:0]  priv_lvl,
    input logic        virt_on,
    input logic        menable_ind,
    input logic        henable_ind,
    input logic        sel_unimpl,
    input logic        fault_illegal,
    input logic        fault_virtual
);
    logic in_win, mach_w, sup_w, vsup_w, not_m, lower_ok;

    assign in_win = (csr_addr[3:0] <= 4'd7) && (csr_addr[3:0] != 4'd4);
    assign mach_w = in_win && (csr_addr[11:4] == 8'h35);
    assign sup_w  = in_win && (csr_addr[11:4] == 8'h15);
    assign vsup_w = in_win && (csr_addr[11:4] == 8'h25);
    assign not_m  = (priv_lvl != 2'b11);
    assign lower_ok = !HAS_STATEEN || menable_ind;

    p_one_fault_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_illegal && fault_virtual));

    p_outside_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mach_w || sup_w || vsup_w) |=> (!fault_illegal && !fault_virtual));

    p_mach_lower_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mach_w && not_m) |=> (fault_illegal || fault_virtual));

    p_menable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_STATEEN && (sup_w || vsup_w) && not_m && !menable_ind)
        |=> (fault_illegal && !fault_virtual));

    p_mmode_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((sup_w || (vsup_w && HAS_HYP)) && !not_m && csr_addr[3:0] == 4'd0)
        |=> (!fault_illegal && !fault_virtual));

    p_vsup_virt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_HYP && vsup_w && not_m && virt_on && lower_ok)
        |=> (fault_virtual && !fault_illegal));

    p_user_sup_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((sup_w || vsup_w) && priv_lvl == 2'b00 && !virt_on)
        |=> fault_illegal);

    p_unimpl_alias_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mach_w && !not_m && csr_addr[3:0] != 4'd0 && sel_unimpl)
        |=> fault_illegal);

    logic unused_ok;
    assign unused_ok = henable_ind;

endmodule

bind csri_access_checker csri_access_checker_sva #(
    .HAS_HYP     (HAS_HYP),
    .HAS_STATEEN (HAS_STATEEN)
) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .csr_addr      (csr_addr),
    .priv_lvl      (priv_lvl),
    .virt_on       (virt_on),
    .menable_ind   (menable_ind),
    .henable_ind   (henable_ind),
    .sel_unimpl    (sel_unimpl),
    .fault_illegal (fault_illegal),
    .fault_virtual (fault_virtual)
);

// File: tb/tb_csri_access_checker.sv
`timescale 1ns/1ps
module tb_csri_access_checker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr = 12'h350;
    logic [1:0]  priv_lvl = 2'b00;
    logic        virt_on = 1'b1;
    logic        menable_ind = 1'b0;
    logic        henable_ind = 1'b0;
    logic        sel_unimpl = 1'b1;
    logic        fault_illegal, fault_virtual;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    csri_access_checker dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .csr_addr      (csr_addr),
        .priv_lvl      (priv_lvl),
        .virt_on       (virt_on),
        .menable_ind   (menable_ind),
        .henable_ind   (henable_ind),
        .sel_unimpl    (sel_unimpl),
        .fault_illegal (fault_illegal),
        .fault_virtual (fault_virtual)
    );

    // Expected {illegal, virtual}, derived from the requirement list.
    function automatic logic [1:0] model(input logic [11:0] a, input logic [1:0] p,
                                         input logic v, input logic me, input logic he,
                                         input logic un, output string tag);
        logic [3:0] off;
        logic inw, m, u, vs, vu, alias_acc;
        off = a[3:0];
        inw = (off <= 4'd7) && (off != 4'd4);
        m = (p == 2'b11); u = (p == 2'b00);
        vs = v && (p == 2'b01); vu = v && u;
        alias_acc = (off != 4'd0);
        if (!inw || !(a[11:4] == 8'h35 || a[11:4] == 8'h15 || a[11:4] == 8'h25)) begin
            tag = "R2"; return 2'b00;
        end
        if (a[11:4] == 8'h35) begin
            if (!m) begin tag = "R3"; return v ? 2'b01 : 2'b10; end
            if (alias_acc && un) begin tag = "R10"; return 2'b10; end
            tag = "R5"; return 2'b00;
        end
        if (!m && !me) begin tag = "R4"; return 2'b10; end
        if (a[11:4] == 8'h25 && (vs || vu)) begin tag = "R6"; return 2'b01; end
        if (a[11:4] == 8'h15 && vu) begin tag = "R7"; return 2'b01; end
        if (a[11:4] == 8'h15 && vs && !he) begin tag = "R8"; return 2'b01; end
        if (u) begin tag = "R9"; return 2'b10; end
        if (alias_acc && un) begin tag = "R10"; return 2'b10; end
        tag = m ? "R5" : "R10";
        return 2'b00;
    endfunction

    task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp,
                         input logic [11:0] a);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s addr=%h got={ill,virt}=%b expected=%b", tag, a, got, exp);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog expired got=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [11:0] addrs [40];
        logic [1:0]  pl [5];
        logic        vl [5];
        int n;
        string tag;
        logic [1:0] exp;
        n = 0;
        for (int w = 0; w < 3; w++) begin
            for (int o = 0; o < 9; o++) begin
                addrs[n] = {4'(w + 1), 4'h5, 4'(o)};
                n++;
            end
            addrs[n] = {4'(w + 1), 4'h4, 4'hF};
            n++;
        end
        addrs[n] = 12'h000; n++;
        addrs[n] = 12'hFFF; n++;
        addrs[n] = 12'h15C; n++;
        addrs[n] = 12'h750; n++;
        pl[0] = 2'b00; vl[0] = 1'b0;
        pl[1] = 2'b01; vl[1] = 1'b0;
        pl[2] = 2'b11; vl[2] = 1'b0;
        pl[3] = 2'b00; vl[3] = 1'b1;
        pl[4] = 2'b01; vl[4] = 1'b1;

        // R1: reset holds outputs low under a faulting request
        repeat (3) @(negedge clk);
        check("R1", {fault_illegal, fault_virtual}, 2'b00, csr_addr);
        rst_n = 1'b1;

        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 5; k++) begin
                for (int e = 0; e < 8; e++) begin
                    @(negedge clk);
                    csr_addr = addrs[i];
                    priv_lvl = pl[k];
                    virt_on = vl[k];
                    menable_ind = e[2];
                    henable_ind = e[1];
                    sel_unimpl = e[0];
                    exp = model(addrs[i], pl[k], vl[k], e[2], e[1], e[0], tag);
                    @(negedge clk);
                    check(tag, {fault_illegal, fault_virtual}, exp, addrs[i]);
                    // R11: at most one fault
                    check("R11", {1'b0, fault_illegal & fault_virtual}, 2'b00, addrs[i]);
                end
            end
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule